// File: doc/BRIEF.md
# Pulse Leading-Edge Timing Extractor

This block watches a stream of digitized detector samples, one per accepted clock, and reports each pulse with a time finer than one sample period. A pulse opens when a sample rises above a threshold that software sets. The block then follows the rising edge until the first sample that does not climb, and that sample confirms the peak. The two samples just before the peak are reduced to their upper bits and used as the address of a phase table. The table returns the point inside the sample period where the edge crosses half height, in 1/64ths of a period. No divider sits in the sample path.

Each report carries four values. The coarse time is the free-running sample index of the earlier pre-peak sample. The other three are the 6-bit fine code, the peak amplitude and a flag telling whether the edge was long enough to give a trustworthy phase. A one-cycle strobe marks every report. After a report, the block stays disarmed until the signal drops below the threshold again.

Top module: `pulse_edge_timer`

## Requirements
- R1: While armed, a pulse starts on an accepted sample strictly greater than `thr`. A sample equal to `thr` starts nothing.
- R2: The peak is the last sample before the first accepted sample that is less than or equal to it. When two samples are equal, the earlier one is the peak.
- R3: `out_valid` is high for exactly one cycle, after the clock edge that accepts the confirming (non-increasing) sample. It is low at all other times.
- R4: `out_peak` carries the full-width value of the peak sample.
- R5: `out_coarse` is the index of the earlier pre-peak sample, which equals the peak index minus 2. Sample indices come from a counter that starts at 0 after reset, counts accepted samples only and wraps modulo 2^CNT_W.
- R6: For a valid report, `out_fine` is the table value at address {E, L}. E is bits [9:2] of the earlier pre-peak sample and sits in the high byte; L is bits [9:2] of the later one. The value is 0 when L = 0, and otherwise min(63, floor(64*E/L)).
- R7: If the peak lies fewer than two accepted samples after the sample that started the pulse, `out_ok` is 0 and `out_fine` is 0. `out_peak` and `out_coarse` are still reported. Otherwise `out_ok` is 1.
- R8: After a report, no new pulse starts until an accepted sample is strictly below `thr`. The confirming sample counts for this if it is below `thr`.
- R9: A sample presented with `in_valid` low has no effect. It does not touch the pulse state, the history or the sample counter.
- R10: Reset clears all outputs to 0, arms the detector, empties the history and sets the sample counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | SMP_W | ADC code |
| thr | input | SMP_W | Pulse start threshold |
| out_valid | output | 1 | One-cycle report strobe |
| out_ok | output | 1 | Edge long enough for a phase estimate |
| out_coarse | output | CNT_W | Sample index of the earlier pre-peak sample |
| out_fine | output | FINE_W | Phase within the sample period, 1/64 units |
| out_peak | output | SMP_W | Peak amplitude |

## Verification
The bound assertions check several properties on every cycle. The strobe never lasts two cycles, and each confirmed peak is followed by exactly one strobe. An invalid report always carries a zero phase. A confirmation on a sample at or above threshold is never followed at once by a new pulse start, and no event fires on an unqualified sample. The bench scenarios cover what needs whole sample sequences: which sample wins on a tie, the table values for different edge shapes, coarse indices across counter wrap and input gaps, and the cleared state after a reset in the middle of a pulse.

// File: rtl/pet_pkg.sv
package pet_pkg;
  // Pulse tracker states: waiting for a crossing, climbing the edge,
  // waiting for the signal to drop below threshold after a report.
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_RISE  = 2'd1,
    ST_HOLD  = 2'd2
  } trk_state_e;
endpackage

// File: rtl/sample_hist.sv
// Sample history: stage 0 keeps the full sample (peak amplitude), deeper
// stages keep only the table key bits of older samples.
module sample_hist #(
  parameter int SMP_W = 10,
  parameter int KEY_W = 8,
  parameter int DEPTH = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift_en,
  input  logic [SMP_W-1:0]            din,
  output logic [SMP_W-1:0]            newest,
  output logic [DEPTH-1:1][KEY_W-1:0] keys
);
  always_ff @(posedge clk) begin
    if (!rst_n)        newest <= '0;
    else if (shift_en) newest <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    logic [KEY_W-1:0] stage_in;
    if (g == 1) begin : g_first
      assign stage_in = newest[SMP_W-1 -: KEY_W];
    end else begin : g_next
      assign stage_in = keys[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)        keys[g] <= '0;
      else if (shift_en) keys[g] <= stage_in;
    end
  end
endmodule

// File: rtl/pulse_tracker.sv
// Threshold crossing, peak search and re-arm control.
module pulse_tracker import pet_pkg::*; #(
  parameter int SMP_W    = 10,
  parameter int MIN_RISE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_sample,
  input  logic [SMP_W-1:0] thr,
  output logic             start_evt,
  output logic             confirm,
  output logic             lead_ok
);
  localparam int RC_W = $clog2(MIN_RISE + 1);

  trk_state_e       state;
  logic [SMP_W-1:0] cand;
  logic [RC_W-1:0]  rise_cnt;
  logic             rising;

  always_comb begin
    start_evt = in_valid && (state == ST_ARMED) && (in_sample > thr);
    rising    = in_valid && (state == ST_RISE) && (in_sample > cand);
    confirm   = in_valid && (state == ST_RISE) && (in_sample <= cand);
    lead_ok   = (rise_cnt >= RC_W'(MIN_RISE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_ARMED;
      cand     <= '0;
      rise_cnt <= '0;
    end else begin
      case (state)
        ST_ARMED: if (start_evt) begin
          state    <= ST_RISE;
          cand     <= in_sample;
          rise_cnt <= '0;
        end
        ST_RISE: begin
          if (rising) begin
            cand <= in_sample;
            if (rise_cnt < RC_W'(MIN_RISE)) rise_cnt <= rise_cnt + 1'b1;
          end
          if (confirm) state <= (in_sample < thr) ? ST_ARMED : ST_HOLD;
        end
        ST_HOLD: if (in_valid && (in_sample < thr)) state <= ST_ARMED;
        default: state <= ST_ARMED;
      endcase
    end
  end
endmodule

// File: rtl/edge_lut.sv
// Phase table addressed by {earlier key, later key}; contents are a
// function of the address, so no stored image is needed.
module edge_lut #(
  parameter int KEY_W  = 8,
  parameter int FINE_W = 6
) (
  input  logic [KEY_W-1:0]  key_early,
  input  logic [KEY_W-1:0]  key_late,
  output logic [FINE_W-1:0] code
);
  localparam int NUM_W = KEY_W + FINE_W;
  localparam logic [NUM_W-1:0] MAXC = NUM_W'((1 << FINE_W) - 1);

  function automatic logic [FINE_W-1:0] phase_code(
    input logic [KEY_W-1:0] e, input logic [KEY_W-1:0] l);
    logic [NUM_W-1:0] num, den, q;
    if (l == '0) return '0;
    num = {e, {FINE_W{1'b0}}};
    den = {{FINE_W{1'b0}}, l};
    q   = num / den;
    if (q > MAXC) return '1;
    return q[FINE_W-1:0];
  endfunction

  assign code = phase_code(key_early, key_late);
endmodule

// File: rtl/pulse_edge_timer.sv
module pulse_edge_timer import pet_pkg::*; #(
  parameter int SMP_W  = 10,
  parameter int KEY_W  = 8,
  parameter int FINE_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SMP_W-1:0]  in_sample,
  input  logic [SMP_W-1:0]  thr,
  output logic              out_valid,
  output logic              out_ok,
  output logic [CNT_W-1:0]  out_coarse,
  output logic [FINE_W-1:0] out_fine,
  output logic [SMP_W-1:0]  out_peak
);
  localparam int HIST_D   = 3;
  localparam int MIN_RISE = 2;

  logic                        start_evt, confirm, lead_ok;
  logic [CNT_W-1:0]            smp_cnt;
  logic [SMP_W-1:0]            peak_smp;
  logic [HIST_D-1:1][KEY_W-1:0] pre_keys;
  logic [FINE_W-1:0]           phase;

  // The current sample confirms the peak; the peak sits one index back and
  // the earlier pre-peak sample three indices back.
  function automatic logic [CNT_W-1:0] coarse_of(input logic [CNT_W-1:0] c);
    return c - CNT_W'(HIST_D);
  endfunction

  pulse_tracker #(.SMP_W(SMP_W), .MIN_RISE(MIN_RISE)) u_trk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .thr(thr), .start_evt(start_evt), .confirm(confirm), .lead_ok(lead_ok)
  );

  sample_hist #(.SMP_W(SMP_W), .KEY_W(KEY_W), .DEPTH(HIST_D)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_sample),
    .newest(peak_smp), .keys(pre_keys)
  );

  edge_lut #(.KEY_W(KEY_W), .FINE_W(FINE_W)) u_lut (
    .key_early(pre_keys[2]), .key_late(pre_keys[1]), .code(phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        smp_cnt <= '0;
    else if (in_valid) smp_cnt <= smp_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_ok     <= 1'b0;
      out_coarse <= '0;
      out_fine   <= '0;
      out_peak   <= '0;
    end else begin
      out_valid <= confirm;
      if (confirm) begin
        out_ok     <= lead_ok;
        out_fine   <= lead_ok ? phase : '0;
        out_peak   <= peak_smp;
        out_coarse <= coarse_of(smp_cnt);
      end
    end
  end
endmodule

// File: rtl/pulse_edge_timer_chk.sv
module pulse_edge_timer_chk #(
  parameter int SMP_W  = 10,
  parameter int FINE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [SMP_W-1:0]  in_sample,
  input logic [SMP_W-1:0]  thr,
  input logic              out_valid,
  input logic              out_ok,
  input logic [FINE_W-1:0] out_fine,
  input logic              confirm,
  input logic              start_evt
);
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_confirm_reports_r3: assert property (@(posedge clk) disable iff (!rst_n)
    confirm |=> out_valid);

  p_report_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(confirm));

  p_invalid_zero_fine_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ok) |-> (out_fine == '0));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (confirm && (in_sample >= thr)) |=> !start_evt);

  p_events_need_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || confirm) |-> in_valid);
endmodule

bind pulse_edge_timer pulse_edge_timer_chk #(.SMP_W(SMP_W), .FINE_W(FINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
  .thr(thr), .out_valid(out_valid), .out_ok(out_ok), .out_fine(out_fine),
  .confirm(confirm), .start_evt(start_evt)
);

// File: tb/test_pulse_edge_timer.sv
`timescale 1ns/1ps
module test_pulse_edge_timer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [9:0]    in_sample = '0;
  logic [9:0]    thr = 10'd100;
  logic          out_valid, out_ok;
  logic [CW-1:0] out_coarse;
  logic [5:0]    out_fine;
  logic [9:0]    out_peak;

  pulse_edge_timer #(.SMP_W(10), .KEY_W(8), .FINE_W(6), .CNT_W(CW)) i_pulse_edge_timer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .thr(thr), .out_valid(out_valid), .out_ok(out_ok), .out_coarse(out_coarse),
    .out_fine(out_fine), .out_peak(out_peak)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [CW-1:0] sent = '0;
  int rep_n = 0;
  logic       rep_ok [16];
  logic [5:0] rep_fine [16];
  logic [9:0] rep_peak [16];
  logic [CW-1:0] rep_coarse [16];
  bit done = 0;

  // 8 samples (index 0 in the top bits), then hit, peak position, ok.
  localparam logic [84:0] VECS [8] = '{
    {10'd0, 10'd120, 10'd300, 10'd600, 10'd800, 10'd700, 10'd0, 10'd0, 1'b1, 3'd4, 1'b1},
    {10'd0, 10'd0, 10'd200, 10'd400, 10'd400, 10'd300, 10'd0, 10'd0, 1'b1, 3'd3, 1'b0},
    {10'd0, 10'd150, 10'd500, 10'd900, 10'd1000, 10'd1023, 10'd500, 10'd0, 1'b1, 3'd5, 1'b1},
    {10'd101, 10'd200, 10'd300, 10'd100, 10'd0, 10'd0, 10'd0, 10'd0, 1'b1, 3'd2, 1'b1},
    {10'd100, 10'd100, 10'd50, 10'd100, 10'd0, 10'd0, 10'd0, 10'd0, 1'b0, 3'd0, 1'b0},
    {10'd0, 10'd200, 10'd600, 10'd2, 10'd0, 10'd0, 10'd0, 10'd0, 1'b1, 3'd2, 1'b0},
    {10'd0, 10'd110, 10'd112, 10'd1000, 10'd0, 10'd0, 10'd0, 10'd0, 1'b1, 3'd3, 1'b1},
    {10'd0, 10'd200, 10'd400, 10'd800, 10'd800, 10'd0, 10'd0, 10'd0, 1'b1, 3'd3, 1'b1}
  };

  function automatic int ref_fine(int early, int late);
    int a, b, n, q;
    a = early / 4; b = late / 4; q = 0;
    if (b == 0) return 0;
    n = a * 64;
    while (n >= b && q < 63) begin n = n - b; q = q + 1; end
    return q;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] x, input logic v);
    in_sample = x; in_valid = v;
    @(posedge clk); #1;
    if (v) sent = sent + 1'b1;
    if (out_valid && rep_n < 16) begin
      rep_ok[rep_n] = out_ok; rep_fine[rep_n] = out_fine;
      rep_peak[rep_n] = out_peak; rep_coarse[rep_n] = out_coarse;
    end
    if (out_valid) rep_n++;
  endtask

  task automatic chk_zero_outputs(input string tag);
    chk({tag, " valid"}, int'(out_valid), 0);
    chk({tag, " ok"}, int'(out_ok), 0);
    chk({tag, " peak"}, int'(out_peak), 0);
    chk({tag, " coarse"}, int'(out_coarse), 0);
    chk({tag, " fine"}, int'(out_fine), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] base;
    repeat (3) @(posedge clk); #1;
    chk_zero_outputs("R10 reset");
    rst_n = 1'b1;
    sent = '0;

    // Table walk: R1, R2, R4, R5, R6, R7
    for (int v = 0; v < 8; v++) begin
      int pos, pk, ef, ls, lf;
      push(10'd0, 1'b1);
      base = sent; rep_n = 0;
      for (int i = 0; i < 8; i++) push(VECS[v][84-10*i -: 10], 1'b1);
      chk($sformatf("R1 R3 report count v%0d", v), rep_n, int'(VECS[v][4]));
      if (VECS[v][4]) begin
        pos = int'(VECS[v][3:1]);
        pk  = int'(VECS[v][84-10*pos -: 10]);
        ef  = int'(VECS[v][84-10*(pos-2) -: 10]);
        ls  = int'(VECS[v][84-10*(pos-1) -: 10]);
        lf  = VECS[v][0] ? ref_fine(ef, ls) : 0;
        chk($sformatf("R2 R4 peak v%0d", v), int'(rep_peak[0]), pk);
        chk($sformatf("R5 coarse v%0d", v), int'(rep_coarse[0]), int'(CW'(base + CW'(pos - 2))));
        chk($sformatf("R7 ok v%0d", v), int'(rep_ok[0]), int'(VECS[v][0]));
        chk($sformatf("R6 fine v%0d", v), int'(rep_fine[0]), lf);
      end
    end

    // R8: confirmation above threshold keeps the detector disarmed
    rep_n = 0;
    foreach (VECS[0][i]) ; // no-op keeps loop style uniform
    push(10'd0, 1'b1); push(10'd200, 1'b1); push(10'd500, 1'b1); push(10'd300, 1'b1);
    push(10'd400, 1'b1); push(10'd800, 1'b1); push(10'd900, 1'b1); push(10'd200, 1'b1);
    push(10'd50, 1'b1);
    chk("R8 held while above threshold", rep_n, 1);
    chk("R8 first peak", int'(rep_peak[0]), 500);
    rep_n = 0;
    push(10'd150, 1'b1); push(10'd300, 1'b1); push(10'd700, 1'b1); push(10'd0, 1'b1);
    chk("R8 rearmed after low sample", rep_n, 1);
    chk("R8 rearmed peak", int'(rep_peak[0]), 700);

    // R8: confirming sample below threshold rearms at once
    rep_n = 0;
    push(10'd0, 1'b1); push(10'd200, 1'b1); push(10'd500, 1'b1); push(10'd50, 1'b1);
    push(10'd200, 1'b1); push(10'd400, 1'b1); push(10'd800, 1'b1); push(10'd0, 1'b1);
    chk("R8 back-to-back count", rep_n, 2);
    chk("R8 second peak", int'(rep_peak[1]), 800);
    chk("R8 second ok", int'(rep_ok[1]), 1);

    // R9: a gap sample is ignored
    push(10'd0, 1'b1);
    base = sent; rep_n = 0;
    push(10'd200, 1'b1); push(10'd999, 1'b0); push(10'd400, 1'b1);
    push(10'd800, 1'b1); push(10'd0, 1'b1);
    chk("R9 gap count", rep_n, 1);
    chk("R9 gap peak", int'(rep_peak[0]), 800);
    chk("R9 gap coarse", int'(rep_coarse[0]), int'(base));
    chk("R9 gap fine", int'(rep_fine[0]), ref_fine(200, 400));

    // R5: counter wrap; earlier pre-peak sample at the last index
    while (sent != CW'(255)) push(10'd0, 1'b1);
    rep_n = 0;
    push(10'd200, 1'b1); push(10'd400, 1'b1); push(10'd800, 1'b1); push(10'd0, 1'b1);
    chk("R5 wrap count", rep_n, 1);
    chk("R5 wrap coarse", int'(rep_coarse[0]), 255);
    chk("R5 wrap ok", int'(rep_ok[0]), 1);

    // R10: reset in the middle of a pulse
    push(10'd0, 1'b1); push(10'd300, 1'b1); push(10'd600, 1'b1);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk_zero_outputs("R10 mid-pulse reset");
    rst_n = 1'b1; sent = '0; rep_n = 0;
    push(10'd900, 1'b1); push(10'd0, 1'b1);
    chk("R10 fresh pulse count", rep_n, 1);
    chk("R10 fresh peak", int'(rep_peak[0]), 900);
    chk("R10 R7 fresh ok", int'(rep_ok[0]), 0);
    chk("R10 R5 fresh coarse", int'(rep_coarse[0]), 254);
    push(10'd0, 1'b1);
    chk("R3 strobe drops", int'(out_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule